// File: doc/BRIEF.md
# Byte-Lane Serial Transmitter Front End

This block is the double-buffered transmit side of an 11-bit asynchronous serial port that hangs off a 24-bit data bus. Software reaches one byte-wide holding register through four write selects. Three of them take one byte lane of the bus word (low, middle or high), so a 24-bit word can be sent as three frames without shifting it in software. The fourth takes the low lane and, in multidrop mode, marks the frame as an address frame.

When the shifter is free, the holding register moves into it on its own. After a fixed gap of two idle bit times, aligned to the next baud tick, the frame leaves on `txd`. The frame is a start bit, eight data bits, a ninth bit and a stop bit. The ninth bit is the address marker in multidrop mode and even parity otherwise. The bit clock is an input strobe: `baud_tick` pulses once per bit time.

Status outputs report an empty holding register and an empty shifter. An interrupt request follows the first of these when interrupts are enabled.

Top module: `tx_lane_front`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `shift_empty` is 1.
- R2: A write with `wr_sel` 0, 1 or 2 loads bus bits 7:0, 15:8 or 23:16 respectively as the frame's data byte.
- R3: A write with `wr_sel` 3 loads bus bits 7:0. In multidrop mode (`multidrop_en`=1) it sets the ninth bit to 1. In multidrop mode, a write with `wr_sel` 0, 1 or 2 gives a ninth bit of 0.
- R4: Any write clears `hold_empty` on the next cycle.
- R5: The holding register transfers to the shifter in the first cycle in which the shifter is empty and the holding register is full. `hold_empty` returns to 1 one cycle later. While the shifter is busy, a second write waits in the holding register and is sent after the first frame.
- R6: The start bit appears on `txd` at the third baud tick after the transfer. This is two whole idle bit times plus alignment, and lies within 2 to 4 bit times.
- R7: A frame is, in time order: start bit 0, eight data bits, ninth bit, stop bit 1. `txd` changes only in a cycle that follows a `baud_tick`.
- R8: With `msb_first`=0 the data bits go out bit 0 first; with `msb_first`=1 they go out bit 7 first. The value is taken at the transfer.
- R9: With `multidrop_en`=0 the ninth bit is the XOR of the eight data bits (even parity).
- R10: `irq` is 1 exactly when `hold_empty` is 1 and `irq_en` is 1.
- R11: `shift_empty` is 0 from the cycle after the transfer until the stop bit's tick has passed. `txd` is 1 whenever `shift_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_sel | input | 2 | 0 low lane, 1 middle lane, 2 high lane, 3 address port |
| wr_data | input | 24 | Bus word |
| multidrop_en | input | 1 | Ninth bit is the address marker instead of parity |
| msb_first | input | 1 | Data bit order select |
| irq_en | input | 1 | Transmit interrupt enable |
| baud_tick | input | 1 | One-cycle strobe per bit time |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding register can be written |
| shift_empty | output | 1 | Shifter is idle |
| irq | output | 1 | Transmit interrupt request |

## Verification
A holding-full flag stuck at the wrong value shows within one cycle, as a wrong `hold_empty` or `irq`, or as a frame lost or repeated on the line. A delay counter or bit index off by one moves the start bit or the return of `shift_empty` by a whole bit time. That error is visible within one frame. A wrong lane pick, bit order or ninth-bit source appears as a single wrong bit in the decoded frame. The bench therefore compares all outputs against a behavioural model on every clock and also decodes the line into frames.

// File: rtl/tx_lane_pkg.sv
package tx_lane_pkg;
   typedef enum logic [1:0] {
      SH_IDLE = 2'd0,
      SH_WAIT = 2'd1,
      SH_SEND = 2'd2
   } sh_state_t;
endpackage

// File: rtl/tx_lane_hold.sv
module tx_lane_hold #(
   parameter int LANE_W = 8,
   parameter int LANES  = 3,
   localparam int SEL_W  = $clog2(LANES + 1),
   localparam int DATA_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              multidrop_en,
   input  logic              take,
   output logic [LANE_W-1:0] hold_byte,
   output logic              hold_addr,
   output logic              hold_full
);
   logic [LANE_W-1:0] lanes [LANES];
   logic [LANE_W-1:0] pick;
   logic              is_addr;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lanes[g] = wr_data[g*LANE_W +: LANE_W];
   end

   always_comb begin
      pick = lanes[0];
      for (int i = 1; i < LANES; i++) begin
         if (wr_sel == SEL_W'(i)) pick = lanes[i];
      end
   end

   assign is_addr = (wr_sel == SEL_W'(LANES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_byte <= '0;
         hold_addr <= 1'b0;
         hold_full <= 1'b0;
      end else if (wr_en) begin
         hold_byte <= pick;
         hold_addr <= is_addr && multidrop_en;
         hold_full <= 1'b1;
      end else if (take) begin
         hold_full <= 1'b0;
      end
   end
endmodule

// File: rtl/tx_lane_shifter.sv
module tx_lane_shifter
   import tx_lane_pkg::*;
#(
   parameter int LANE_W    = 8,
   parameter int IDLE_BITS = 2,
   localparam int FRAME_W = LANE_W + 3,
   localparam int IDX_W   = $clog2(FRAME_W),
   localparam int CNT_W   = $clog2(IDLE_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LANE_W-1:0] data,
   input  logic              addr_bit,
   input  logic              multidrop_en,
   input  logic              msb_first,
   input  logic              baud_tick,
   output logic              txd,
   output logic              idle
);
   sh_state_t          state_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [IDX_W-1:0]   idx_q;
   logic [FRAME_W-1:0] frame_q;
   logic [LANE_W-1:0]  rev;
   logic [LANE_W-1:0]  ordered;
   logic               ninth;

   for (genvar g = 0; g < LANE_W; g++) begin : g_rev
      assign rev[g] = data[LANE_W-1-g];
   end

   assign ordered = msb_first ? rev : data;
   assign ninth   = multidrop_en ? addr_bit : ^data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SH_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         frame_q <= '1;
      end else begin
         unique case (state_q)
            SH_IDLE: begin
               if (load) begin
                  frame_q <= {1'b1, ninth, ordered, 1'b0};
                  cnt_q   <= '0;
                  idx_q   <= '0;
                  state_q <= SH_WAIT;
               end
            end
            SH_WAIT: begin
               if (baud_tick) begin
                  if (cnt_q == CNT_W'(IDLE_BITS)) state_q <= SH_SEND;
                  else                            cnt_q   <= cnt_q + 1'b1;
               end
            end
            SH_SEND: begin
               if (baud_tick) begin
                  if (idx_q == IDX_W'(FRAME_W - 1)) begin
                     state_q <= SH_IDLE;
                  end else begin
                     frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
                     idx_q   <= idx_q + 1'b1;
                  end
               end
            end
            default: state_q <= SH_IDLE;
         endcase
      end
   end

   assign txd  = (state_q == SH_SEND) ? frame_q[0] : 1'b1;
   assign idle = (state_q == SH_IDLE);
endmodule

// File: rtl/tx_lane_front.sv
module tx_lane_front #(
   parameter int LANE_W    = 8,
   parameter int LANES     = 3,
   parameter int IDLE_BITS = 2,
   localparam int SEL_W  = $clog2(LANES + 1),
   localparam int DATA_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              multidrop_en,
   input  logic              msb_first,
   input  logic              irq_en,
   input  logic              baud_tick,
   output logic              txd,
   output logic              hold_empty,
   output logic              shift_empty,
   output logic              irq
);
   if (LANE_W < 2) begin : g_bad_lane
      $error("tx_lane_front: LANE_W must be at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("tx_lane_front: LANES must be at least 1");
   end
   if (IDLE_BITS < 2 || IDLE_BITS > 3) begin : g_bad_idle
      $error("tx_lane_front: IDLE_BITS must be 2 or 3 to stay inside the 2..4 bit window");
   end

   logic [LANE_W-1:0] hold_byte;
   logic              hold_addr;
   logic              hold_full;
   logic              sh_idle;
   logic              take;

   assign take = hold_full && sh_idle;

   tx_lane_hold #(.LANE_W(LANE_W), .LANES(LANES)) u_hold (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_data      (wr_data),
      .multidrop_en (multidrop_en),
      .take         (take),
      .hold_byte    (hold_byte),
      .hold_addr    (hold_addr),
      .hold_full    (hold_full)
   );

   tx_lane_shifter #(.LANE_W(LANE_W), .IDLE_BITS(IDLE_BITS)) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (take),
      .data         (hold_byte),
      .addr_bit     (hold_addr),
      .multidrop_en (multidrop_en),
      .msb_first    (msb_first),
      .baud_tick    (baud_tick),
      .txd          (txd),
      .idle         (sh_idle)
   );

   assign hold_empty  = !hold_full;
   assign shift_empty = sh_idle;
   assign irq         = hold_empty && irq_en;
endmodule

// File: rtl/tx_lane_front_chk.sv
module tx_lane_front_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic irq_en,
   input logic baud_tick,
   input logic txd,
   input logic hold_empty,
   input logic shift_empty,
   input logic irq
);
   a_r4_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !hold_empty);

   a_r5_refill_needs_free_shifter: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_empty) |-> $past(shift_empty));

   a_r5_shifter_loads_from_full: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shift_empty) |-> $past(!hold_empty));

   a_r7_txd_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(txd) |-> $past(baud_tick));

   a_r10_irq_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (hold_empty && irq_en));

   a_r10_irq_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_empty && irq_en) |-> irq);

   a_r11_line_high_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      shift_empty |-> txd);
endmodule

bind tx_lane_front tx_lane_front_chk u_chk (.*);

// File: tb/tx_lane_front_bench.sv
`timescale 1ns/1ps
module tx_lane_front_bench;
   localparam int DIV  = 8;
   localparam int IDLE = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [23:0] wr_data = '0;
   logic        multidrop_en = 1'b0;
   logic        msb_first = 1'b0;
   logic        irq_en = 1'b0;
   logic        baud_tick = 1'b0;
   logic        txd, hold_empty, shift_empty, irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   int cyc    = 0;

   always #4 clk = ~clk;

   tx_lane_front u_tx_lane_front (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .multidrop_en(multidrop_en), .msb_first(msb_first), .irq_en(irq_en),
      .baud_tick(baud_tick), .txd(txd), .hold_empty(hold_empty),
      .shift_empty(shift_empty), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // baud strobe
   int tdiv = 0;
   always @(negedge clk) begin
      tdiv = (tdiv == DIV - 1) ? 0 : tdiv + 1;
      baud_tick <= (tdiv == DIV - 1);
   end

   // behavioural reference model
   int   m_state = 0;
   bit   m_full  = 0;
   bit [7:0] m_hold = 0;
   bit   m_addr  = 0;
   int   m_cnt   = 0;
   bit   mq[$];
   bit   tick_q  = 0;

   always @(posedge clk) begin
      cyc++;
      tick_q <= baud_tick;
      if (!rst_n) begin
         m_state = 0; m_full = 0; m_hold = 0; m_addr = 0; m_cnt = 0; mq.delete();
      end else begin
         bit xfer;
         xfer = (m_state == 0) && m_full;
         if (xfer) begin
            bit [7:0] d;
            d = m_hold;
            mq.delete();
            mq.push_back(1'b0);
            for (int i = 0; i < 8; i++) mq.push_back(msb_first ? d[7-i] : d[i]);
            mq.push_back(multidrop_en ? m_addr : ^d);
            mq.push_back(1'b1);
            m_state = 1; m_cnt = 0;
         end else if (m_state == 1 && baud_tick) begin
            if (m_cnt == IDLE) m_state = 2;
            else m_cnt++;
         end else if (m_state == 2 && baud_tick) begin
            void'(mq.pop_front());
            if (mq.size() == 0) m_state = 0;
         end
         if (wr_en) begin
            m_hold = wr_data[wr_sel == 2'd3 ? 0 : wr_sel*8 +: 8];
            m_addr = (wr_sel == 2'd3) && multidrop_en;
            m_full = 1;
         end else if (xfer) begin
            m_full = 0;
         end
      end
   end

   // per-clock comparison, frame capture and delay measurement
   bit   cap = 0;
   bit [10:0] cbuf;
   int   cidx = 0;
   logic [10:0] caps[$];
   bit   armed = 0;
   int   t0 = 0;
   logic prev_he = 1'b1;
   logic prev_txd = 1'b1;

   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         check("R7 txd vs model", txd, (m_state == 2) ? mq[0] : 1'b1);
         check("R4/R5 hold_empty vs model", hold_empty, !m_full);
         check("R11 shift_empty vs model", shift_empty, m_state == 0);
         check("R10 irq vs model", irq, !m_full && irq_en);
         if (tick_q) begin
            if (!cap && txd == 1'b0) begin
               cap = 1; cbuf = '0; cidx = 1;
            end else if (cap) begin
               cbuf[cidx] = txd; cidx++;
               if (cidx == 11) begin cap = 0; caps.push_back(cbuf); end
            end
         end
         if (hold_empty && !prev_he && !shift_empty) begin armed = 1; t0 = cyc; end
         if (!txd && prev_txd && armed) begin
            armed = 0;
            checks++;
            if (cyc - t0 < 2*DIV || cyc - t0 > 4*DIV) begin
               fails++;
               $display("FAIL R6: actual delay %0d cycles expected %0d..%0d", cyc - t0, 2*DIV, 4*DIV);
            end
         end
         prev_he = hold_empty; prev_txd = txd;
      end
   end

   function automatic logic [10:0] mk(input logic [7:0] b, input bit msb, input bit ninth);
      logic [10:0] f;
      f[0] = 1'b0;
      for (int i = 0; i < 8; i++) f[1+i] = msb ? b[7-i] : b[i];
      f[9] = ninth;
      f[10] = 1'b1;
      return f;
   endfunction

   task automatic wr(input logic [1:0] sel, input logic [23:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk); #2;
         if (hold_empty && shift_empty && !cap) break;
      end
   endtask

   task automatic expect_frame(input string req, input logic [10:0] exp);
      logic [10:0] got;
      got = (caps.size() > 0) ? caps.pop_front() : 11'h7ff;
      check(req, got, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #2;
      check("R1 txd", txd, 1'b1);
      check("R1 hold_empty", hold_empty, 1'b1);
      check("R1 shift_empty", shift_empty, 1'b1);
      check("R10 irq off", irq, 1'b0);
      rst_n = 1'b1;
      @(negedge clk); irq_en = 1'b1;
      @(negedge clk); #2;
      check("R10 irq on", irq, 1'b1);

      // R2 low lane, LSB first, parity (R9)
      wr(2'd0, 24'h123456);
      #2;
      check("R4 empty cleared", hold_empty, 1'b0);
      check("R10 irq cleared", irq, 1'b0);
      wait_idle();
      expect_frame("R2 low lane / R9 parity", mk(8'h56, 0, ^8'h56));

      // R2 middle lane, MSB first (R8)
      msb_first = 1'b1;
      wr(2'd1, 24'h12B734);
      wait_idle();
      expect_frame("R2 middle lane / R8 msb first", mk(8'hB7, 1, ^8'hB7));

      // R2 high lane, LSB first
      msb_first = 1'b0;
      wr(2'd2, 24'hC10000);
      wait_idle();
      expect_frame("R2 high lane / R9 odd-weight parity", mk(8'hC1, 0, 1'b1));

      // R3 address port in multidrop mode
      multidrop_en = 1'b1;
      wr(2'd3, 24'hFFFF00);
      wait_idle();
      expect_frame("R3 address frame ninth=1", mk(8'h00, 0, 1'b1));
      wr(2'd2, 24'h7F0000);
      wait_idle();
      expect_frame("R3 lane write ninth=0", mk(8'h7F, 0, 1'b0));
      multidrop_en = 1'b0;
      wr(2'd3, 24'h000003);
      wait_idle();
      expect_frame("R3 address port outside multidrop uses parity", mk(8'h03, 0, 1'b0));

      // R5 double buffering
      wr(2'd0, 24'h0000A5);
      for (int i = 0; i < 100; i++) begin @(negedge clk); #2; if (hold_empty) break; end
      wr(2'd1, 24'h003C00);
      #2;
      check("R5 second waits in hold", hold_empty, 1'b0);
      check("R11 shifter busy", shift_empty, 1'b0);
      wait_idle();
      expect_frame("R5 first frame", mk(8'hA5, 0, 1'b0));
      expect_frame("R5 second frame", mk(8'h3C, 0, 1'b0));
      check("R5 no extra frame", caps.size(), 0);

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule